// File: doc/BRIEF.md
# ROM Self-Diagnosis and Output Correction

This block sits between a small read-only array and its consumers. The array holds N data words of B bits. Two extra words at addresses N and N+1 hold redundancy for the whole array. This is not per-word check information. The first extra word is a plain parity across all the data. The second is a parity in which every word is first multiplied, in GF(2^B), by a field element tied to its address.

A diagnose request starts an off-line pass. The pass walks the data words one per clock and then reads the two redundant words. From these it forms two syndromes. If both syndromes are zero, the array is clean. If both are nonzero, the pass searches for the address whose field element equals the ratio of the two syndromes. That address and the first syndrome, which is the error pattern, are held in registers. After the pass, every ordinary read of that address has the pattern XORed back onto the array output, so the consumer sees the original word. All other addresses pass through unchanged.

The array itself is external and reads asynchronously: `mem_data` reflects `mem_addr` in the same cycle. Faults are assumed to touch at most one address.

Top module: `rom_selfdiag`

## Requirements
- R1: After reset, `busy`, `done`, `fault_found` and `uncorrectable` are 0, and `rd_data` equals `mem_data` for any `rd_addr`.
- R2: The layout of the redundancy is as follows. Address N holds the XOR of data words 0..N-1. Address N+1 holds the XOR over i of d_i·α^i in GF(2^B), where the field is reduced by POLY (default x^8+x^4+x^3+x^2+1, value 0x11D) and α is the element x (value 2). N must not exceed 2^B-1.
- R3: A `start` seen while idle begins a pass. In the cycles after the start edge, `mem_addr` takes 0, 1, …, N-1, then N, then N+1. With a clean array, `done` is high for exactly one cycle, beginning N+3 clock edges after the start edge.
- R4: `start` asserted while a pass is running is ignored: the pass timing and its result are unchanged.
- R5: With a clean array, the pass ends with `fault_found`=0 and `uncorrectable`=0.
- R6: With exactly one data word changed by a nonzero pattern, the pass ends with `fault_found`=1, `uncorrectable`=0 and `fault_addr` equal to that word's address.
- R7: While idle with `fault_found`=1, a read of `fault_addr` returns the original (uncorrupted) word. Reads of every other address return `mem_data` unchanged.
- R8: If exactly one of the two syndromes is zero (for example, only one redundant word is corrupted), the pass ends with `uncorrectable`=1 and `fault_found`=0.
- R9: If both syndromes are nonzero but their ratio is α^k with k outside 0..N-1, the pass ends with `uncorrectable`=1 and correction is off, so every read returns raw `mem_data`.
- R10: Results hold until the next pass. A new start clears `fault_found` and `uncorrectable` from the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a diagnostic pass (taken only when idle) |
| rd_addr | input | AW | Normal-mode read address |
| rd_data | output | B | Corrected read data |
| mem_addr | output | AW | Address to the external array |
| mem_data | input | B | Data from the external array, same cycle |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| fault_found | output | 1 | A single faulty address was located |
| uncorrectable | output | 1 | Syndromes are inconsistent with a single faulty word |
| fault_addr | output | AW | Located faulty address |

## Verification
The assertions assume that `mem_data` is a pure function of `mem_addr` within a cycle. They also assume that the array contents do not change during a pass. The bench models the array as a combinational lookup into its own storage and alters that storage only while the block is idle. Once a fault is located, the bench leaves the corrupted word in place until the next pass, so the claim that the output differs from the raw word at the faulty address stays valid. Random contents and fault patterns come from a fixed seed. The out-of-range locator case is built by corrupting a data word and the second redundant word together, so the ratio of the syndromes lands on α^N.

// File: rtl/rom_selfdiag.sv
module rom_selfdiag #(
  parameter int N = 64,
  parameter int B = 8,
  parameter logic [B:0] POLY = 9'h11D,
  parameter int AW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  output logic [B-1:0]  rd_data,
  output logic [AW-1:0] mem_addr,
  input  logic [B-1:0]  mem_data,
  output logic          busy,
  output logic          done,
  output logic          fault_found,
  output logic          uncorrectable,
  output logic [AW-1:0] fault_addr
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);
  localparam logic [AW-1:0] RED0 = AW'(N);
  localparam logic [AW-1:0] RED1 = AW'(N + 1);

  typedef enum logic [2:0] {IDLE, SCAN, CHK1, CHK2, EVAL, SRCH, FIN} st_t;
  st_t st;

  logic [AW-1:0] cnt;
  logic [B-1:0]  acc1, acc2, w, s1, s2, p, epat;

  function automatic logic [B-1:0] xtime(input logic [B-1:0] v);
    return {v[B-2:0], 1'b0} ^ (v[B-1] ? POLY[B-1:0] : '0);
  endfunction

  function automatic logic [B-1:0] gmul(input logic [B-1:0] a, input logic [B-1:0] b);
    logic [B-1:0] r;
    r = '0;
    for (int i = B - 1; i >= 0; i--)
      r = xtime(r) ^ (b[i] ? a : '0);
    return r;
  endfunction

  always_comb begin
    case (st)
      SCAN:    mem_addr = cnt;
      CHK1:    mem_addr = RED0;
      CHK2:    mem_addr = RED1;
      default: mem_addr = rd_addr;
    endcase
  end

  wire hit = (st == IDLE) && fault_found && (rd_addr == fault_addr);
  assign rd_data = mem_data ^ (hit ? epat : '0);
  assign busy    = (st != IDLE);
  assign done    = (st == FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      acc1 <= '0;
      acc2 <= '0;
      w <= '0;
      s1 <= '0;
      s2 <= '0;
      p <= '0;
      epat <= '0;
      fault_found <= 1'b0;
      uncorrectable <= 1'b0;
      fault_addr <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st <= SCAN;
          cnt <= '0;
          acc1 <= '0;
          acc2 <= '0;
          w <= B'(1);
          epat <= '0;
          fault_found <= 1'b0;
          uncorrectable <= 1'b0;
          fault_addr <= '0;
        end
        SCAN: begin
          acc1 <= acc1 ^ mem_data;
          acc2 <= acc2 ^ gmul(mem_data, w);
          w <= xtime(w);
          if (cnt == LAST) st <= CHK1;
          else cnt <= cnt + 1'b1;
        end
        CHK1: begin
          s1 <= acc1 ^ mem_data;
          st <= CHK2;
        end
        CHK2: begin
          s2 <= acc2 ^ mem_data;
          st <= EVAL;
        end
        EVAL: begin
          if (s1 == '0 && s2 == '0) st <= FIN;
          else if (s1 == '0 || s2 == '0) begin
            uncorrectable <= 1'b1;
            st <= FIN;
          end else begin
            p <= s1;
            cnt <= '0;
            st <= SRCH;
          end
        end
        SRCH: begin
          if (p == s2) begin
            fault_found <= 1'b1;
            fault_addr <= cnt;
            epat <= s1;
            st <= FIN;
          end else if (cnt == LAST) begin
            uncorrectable <= 1'b1;
            st <= FIN;
          end else begin
            p <= xtime(p);
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module rom_selfdiag_chk #(
  parameter int N = 64,
  parameter int B = 8,
  parameter int AW = $clog2(N + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] rd_addr,
  input logic [B-1:0]  rd_data,
  input logic [AW-1:0] mem_addr,
  input logic [B-1:0]  mem_data,
  input logic          busy,
  input logic          done,
  input logic          fault_found,
  input logic          uncorrectable,
  input logic [AW-1:0] fault_addr
);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R3
  pass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_addr <= AW'(N + 1)));

  // R6
  locator_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_found |-> (fault_addr < AW'(N)));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_found && uncorrectable));

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(fault_found && rd_addr == fault_addr)) |-> (rd_data == mem_data));

  // R7
  corrected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fault_found && rd_addr == fault_addr) |-> (rd_data != mem_data));

endmodule

bind rom_selfdiag rom_selfdiag_chk #(.N(N), .B(B), .AW(AW)) chk (.*);

// File: tb/rom_selfdiag_test.sv
`timescale 1ns/1ps
module rom_selfdiag_test;
  localparam int N = 64;
  localparam int B = 8;
  localparam int AW = 7;
  localparam logic [B:0] POLY = 9'h11D;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [B-1:0] rd_data, mem_data;
  logic [AW-1:0] mem_addr, fault_addr;
  logic busy, done, fault_found, uncorrectable;

  logic [B-1:0] rom  [0:N+1];
  logic [B-1:0] gold [0:N+1];

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  assign mem_data = (int'(mem_addr) < N + 2) ? rom[mem_addr] : '0;

  rom_selfdiag #(.N(N), .B(B), .POLY(POLY), .AW(AW)) uut (.*);

  function automatic logic [B-1:0] bxt(input logic [B-1:0] v);
    logic [B:0] t;
    t = {v, 1'b0};
    if (t[B]) t = t ^ POLY;
    return t[B-1:0];
  endfunction

  function automatic logic [B-1:0] bmul(input logic [B-1:0] a, input logic [B-1:0] b);
    logic [B-1:0] r, x;
    r = '0; x = a;
    for (int i = 0; i < B; i++) begin
      if (b[i]) r = r ^ x;
      x = bxt(x);
    end
    return r;
  endfunction

  function automatic logic [B-1:0] apow(input int k);
    logic [B-1:0] v;
    v = 1;
    for (int i = 0; i < k; i++) v = bxt(v);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: fill data words and build the two redundant words
  task automatic fill_rom;
    logic [B-1:0] p1, p2;
    p1 = '0; p2 = '0;
    for (int i = 0; i < N; i++) begin
      rom[i] = B'($urandom);
      p1 = p1 ^ rom[i];
      p2 = p2 ^ bmul(rom[i], apow(i));
    end
    rom[N] = p1; rom[N+1] = p2;
    for (int i = 0; i < N + 2; i++) gold[i] = rom[i];
  endtask

  task automatic restore;
    for (int i = 0; i < N + 2; i++) rom[i] = gold[i];
  endtask

  task automatic run_diag;
    int n;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    #1 chk(fault_found == 0 && uncorrectable == 0 && busy, "R10", {fault_found, uncorrectable}, 0);
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    chk(done, "R3 done reached", done, 1);
    @(negedge clk); #1;
    chk(!done && !busy, "R3 done one cycle", done, 0);
  endtask

  task automatic check_reads(input string tag, input int bad, input bit fixed);
    logic [B-1:0] exp;
    for (int i = 0; i < N; i++) begin
      @(negedge clk) rd_addr = AW'(i);
      #1;
      exp = (i == bad && !fixed) ? rom[i] : gold[i];
      chk(rd_data == exp, tag, rd_data, exp);
    end
  endtask

  task automatic single_fault(input int a, input logic [B-1:0] e);
    restore();
    rom[a] = rom[a] ^ e;
    run_diag();
    chk(fault_found == 1 && uncorrectable == 0, "R6 flags", {fault_found, uncorrectable}, 2);
    chk(fault_addr == AW'(a), "R6 address", fault_addr, a);
    check_reads("R7", a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    fill_rom();
    repeat (3) @(negedge clk);
    rd_addr = AW'(5);
    #1;
    chk(!busy && !done && !fault_found && !uncorrectable, "R1 flags",
        {busy, done, fault_found, uncorrectable}, 0);
    chk(rd_data == rom[5], "R1 passthru", rd_data, rom[5]);
    @(negedge clk) rst_n = 1;

    // R3, R4, R5: directed timing pass on a clean array, with a stray start mid-scan
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < N; i++) begin
      #1 chk(mem_addr == AW'(i), "R3 scan address", mem_addr, i);
      @(negedge clk) start = (i == 4);
    end
    start = 0;
    #1 chk(mem_addr == AW'(N), "R3 first redundant", mem_addr, N);
    @(negedge clk); #1 chk(mem_addr == AW'(N + 1), "R3 second redundant", mem_addr, N + 1);
    @(negedge clk); #1 chk(!done, "R4 no early done", done, 0);
    @(negedge clk); #1 chk(done, "R3 done at N+3", done, 1);
    @(negedge clk); #1 chk(!done && !busy, "R3 single pulse", done, 0);
    chk(!fault_found && !uncorrectable, "R5 clean verdict", {fault_found, uncorrectable}, 0);
    check_reads("R5 reads", -1, 1);

    single_fault(0, B'($urandom_range(1, 255)));
    single_fault(N - 1, B'($urandom_range(1, 255)));
    for (int t = 0; t < 6; t++)
      single_fault($urandom_range(0, N - 1), B'($urandom_range(1, 255)));

    // R10: a clean pass after a located fault clears the verdict
    restore();
    run_diag();
    chk(!fault_found && !uncorrectable, "R10 cleared", {fault_found, uncorrectable}, 0);

    // R8: only one redundant word corrupted
    restore();
    rom[N] = rom[N] ^ 8'h5A;
    run_diag();
    chk(uncorrectable && !fault_found, "R8 first word", {fault_found, uncorrectable}, 1);
    restore();
    rom[N+1] = rom[N+1] ^ 8'h81;
    run_diag();
    chk(uncorrectable && !fault_found, "R8 second word", {fault_found, uncorrectable}, 1);
    check_reads("R8 reads", -1, 1);

    // R9: locator lands on alpha^N, outside the address range
    begin
      logic [B-1:0] e;
      int a;
      restore();
      e = 8'h3C; a = 17;
      rom[a] = rom[a] ^ e;
      rom[N+1] = rom[N+1] ^ bmul(e, apow(a)) ^ bmul(e, apow(N));
      run_diag();
      chk(uncorrectable && !fault_found, "R9 verdict", {fault_found, uncorrectable}, 1);
      check_reads("R9 raw reads", a, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule